// File: doc/BRIEF.md
# Sync-Gated Receive Bit FIFO

This block sits behind a radio demodulator and buffers received data one bit at a time. Each bit arrives with a strobe. The bit reaches a 16-entry first-in first-out store only after two conditions hold. First, the demodulator's data-quality qualifier must be high. Second, a 16-bit synchronization word must have been seen in the stream. The upper byte of that word is fixed at 2Dh, and the lower byte is set by an input (D4h is the usual choice). Noise that comes before a packet therefore never takes up space in the store.

A host reads the stored bits over a serial select and a serial clock. While the host holds the active-low select low, the oldest stored bit appears on the data-out pin. Each rising edge of the serial clock removes that bit. Both host lines are resynchronized to the reference clock.

An interrupt flag stays high while the stored bit count is strictly greater than a programmable threshold. Interrupt-driven hosts set a larger threshold. A polling host sets the threshold to zero and drains bits until the flag falls. A sticky overflow flag records any bit that was lost because the store was full.

Top module: `rx_bit_fifo`

## Requirements
- R1: After reset the store is empty, `host_sdo` is 0, `ovf_flag` is 0 and `irq_flag` is 0 for every threshold.
- R2: A bit strobed while no sync match is held, or while `vdi` is low, is discarded and does not change the stored count.
- R3: The sync word is `{8'h2D, sync_low}` and is compared MSB-first against the latest 16 strobed bits. The bit that completes the match is not stored, and storage begins with the next strobed bit.
- R4: When `vdi` goes low, the sync match is dropped and stored bits are kept. After `vdi` rises again, the full sync word must be matched before any further bit is stored.
- R5: `irq_flag` is 1 exactly when the stored count is greater than `irq_level`.
- R6: While the synchronized select is low, `host_sdo` shows the oldest stored bit, or 0 if the store is empty. While the select is high, `host_sdo` is 0.
- R7: Each rising edge of `host_sclk` removes one bit while the select is low. A rising edge with the select high removes nothing.
- R8: A rising edge of `host_sclk` with the store empty leaves the count at zero, keeps `host_sdo` at 0, and disturbs no later storage.
- R9: A bit strobed while 16 bits are stored is dropped and sets `ovf_flag`. The flag stays set until an `ovf_clr` pulse, and the stored bits are unchanged.
- R10: Bits leave in the order they were stored, across pointer wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_stb | input | 1 | One-cycle strobe marking a demodulated bit |
| bit_val | input | 1 | Demodulated bit value, valid with `bit_stb` |
| vdi | input | 1 | Valid-data qualifier from the demodulator |
| sync_low | input | 8 | Programmable low byte of the sync word |
| irq_level | input | 5 | Fill threshold in bits |
| ovf_clr | input | 1 | Pulse that clears the overflow flag |
| host_sel_n | input | 1 | Active-low FIFO select from the host |
| host_sclk | input | 1 | Host serial clock |
| host_sdo | output | 1 | Serial data out to the host |
| irq_flag | output | 1 | Stored count above threshold |
| ovf_flag | output | 1 | Sticky overflow indication |

## Verification
A strobed bit updates the count and `irq_flag` at the first clock edge after the strobe, and a sync match takes effect at that same edge. A change on `host_sel_n` reaches `host_sdo` after two edges. A rising `host_sclk` removes the head bit at the third edge. The bench therefore drives inputs and samples on falling edges, and it holds every serial clock phase and every select change for four reference cycles before it samples. Expected values come from a bench model of the store and the sync matcher, and that model is updated at the same points.

// File: rtl/rx_bit_fifo_pkg.sv
// Shared constants for the sync-gated receive bit FIFO.
// Assumes: the store depth is a power of two.
package rx_bit_fifo_pkg;
    localparam int FIFO_DEPTH = 16;
    localparam int SYNC_BITS  = 16;
    localparam int SYNC_FIX_W = 8;
    localparam logic [SYNC_FIX_W-1:0] SYNC_FIXED = 8'h2D;
    localparam int CNT_W      = $clog2(FIFO_DEPTH + 1);
    localparam int PTR_W      = $clog2(FIFO_DEPTH);
endpackage

// File: rtl/rxf_sync_gate.sv
// Sync-word gate: shifts strobed bits while unlocked and locks when the latest
// bits equal {fixed high part, programmable low part}. Once locked, every
// strobed bit becomes a store request. Leaving valid-data clears the lock.
// Assumes: bit_stb is at most one cycle per bit.
module rxf_sync_gate #(
    parameter int SYNC_W = 16,
    parameter int FIX_W  = 8,
    parameter logic [FIX_W-1:0] FIX_PART = 8'h2D
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vdi,
    input  logic                bit_stb,
    input  logic                bit_val,
    input  logic [SYNC_W-FIX_W-1:0] prog_part,
    output logic                store_stb,
    output logic                store_bit
);
    localparam int HIST_W = SYNC_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic              locked_q;
    logic [SYNC_W-1:0] target;
    logic              hit;

    // Compare history plus the incoming bit with the full sync word.
    always_comb begin
        target = {FIX_PART, prog_part};
        hit    = ({hist_q, bit_val} == target);
    end

    // Shift history and track lock; a low qualifier clears both.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q   <= '0;
            locked_q <= 1'b0;
        end else if (!vdi) begin
            hist_q   <= '0;
            locked_q <= 1'b0;
        end else if (bit_stb && !locked_q) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_val};
            if (hit) begin
                locked_q <= 1'b1;
            end
        end
    end

    // Store only bits that follow a match while the qualifier is high.
    always_comb begin
        store_stb = bit_stb && vdi && locked_q;
        store_bit = bit_val;
    end

    assert_unlock_on_novdi_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !vdi |=> !locked_q);
    assert_lock_needs_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_q) |-> ($past(bit_stb) && $past(vdi)));
    assert_no_store_unlocked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked_q || !vdi) |-> !store_stb);
endmodule

// File: rtl/rxf_host_sync.sv
// Host line conditioning: two-flop synchronizers on the serial clock and the
// active-low select, plus a rising-edge detector that yields a one-cycle pop.
// Assumes: each serial clock phase lasts at least two reference periods.
module rxf_host_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic host_sclk,
    input  logic host_sel_n,
    output logic sel_active,
    output logic pop_stb
);
    logic [STAGES:0]   sclk_q;
    logic [STAGES-1:0] sel_q;

    // Resynchronize the serial clock; one extra stage feeds the edge detector.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
        end else begin
            sclk_q <= {sclk_q[STAGES-1:0], host_sclk};
        end
    end

    // Resynchronize the select, idling deselected.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '1;
        end else begin
            sel_q <= {sel_q[STAGES-2:0], host_sel_n};
        end
    end

    // Pop on a synchronized rising serial clock while selected.
    always_comb begin
        sel_active = !sel_q[STAGES-1];
        pop_stb    = sclk_q[STAGES-1] && !sclk_q[STAGES] && sel_active;
    end

    assert_pop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pop_stb |=> !pop_stb);
endmodule

// File: rtl/rxf_bit_store.sv
// Bit-wide circular store with occupancy count and sticky overflow.
// A push while full is accepted only when a pop happens in the same cycle.
// Assumes: DEPTH is a power of two so the pointers wrap naturally.
module rxf_bit_store #(
    parameter int DEPTH = 16,
    parameter int PW    = $clog2(DEPTH),
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          push_bit,
    input  logic          pop,
    input  logic          ovf_clr,
    output logic          head_bit,
    output logic [CW-1:0] count,
    output logic          ovf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic [DEPTH-1:0] mem_q;
    logic [PW-1:0]    wr_q;
    logic [PW-1:0]    rd_q;
    logic [CW-1:0]    cnt_q;
    logic             ovf_q;
    logic             pop_ok;
    logic             push_ok;

    // Decide which requests take effect this cycle.
    always_comb begin
        pop_ok  = pop && (cnt_q != '0);
        push_ok = push && ((cnt_q != FULL_CNT) || pop_ok);
    end

    // Write accepted bits into the array.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_q <= '0;
        end else if (push_ok) begin
            mem_q[wr_q] <= push_bit;
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_q  <= '0;
            rd_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push_ok) wr_q <= wr_q + 1'b1;
            if (pop_ok)  rd_q <= rd_q + 1'b1;
            case ({push_ok, pop_ok})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    // Overflow is sticky; a new drop wins over a same-cycle clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
        end else if (push && !push_ok) begin
            ovf_q <= 1'b1;
        end else if (ovf_clr) begin
            ovf_q <= 1'b0;
        end
    end

    // Present the oldest bit, or 0 when empty.
    always_comb begin
        head_bit = (cnt_q != '0) ? mem_q[rd_q] : 1'b0;
        count    = cnt_q;
        ovf      = ovf_q;
    end

    assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= FULL_CNT);
    assert_drop_when_full_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && cnt_q == FULL_CNT) |=> (ovf_q && cnt_q == FULL_CNT));
    assert_ovf_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_q && !ovf_clr) |=> ovf_q);
    assert_empty_pop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && cnt_q == '0) |=> (cnt_q == '0));
    assert_ptr_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q != FULL_CNT) |-> (PW'(wr_q - rd_q) == PW'(cnt_q)));
endmodule

// File: rtl/rx_bit_fifo.sv
// Top of the sync-gated receive bit FIFO: gates demodulated bits by sync
// match and valid-data, buffers them, and serves them to a serial host.
// Assumes: host serial clock at most a quarter of clk, phases >= 2 periods.
module rx_bit_fifo
    import rx_bit_fifo_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       bit_val,
    input  logic       vdi,
    input  logic [7:0] sync_low,
    input  logic [4:0] irq_level,
    input  logic       ovf_clr,
    input  logic       host_sel_n,
    input  logic       host_sclk,
    output logic       host_sdo,
    output logic       irq_flag,
    output logic       ovf_flag
);
    logic             store_stb;
    logic             store_bit;
    logic             sel_active;
    logic             pop_stb;
    logic             head_bit;
    logic [CNT_W-1:0] fill;

    rxf_sync_gate #(
        .SYNC_W   (SYNC_BITS),
        .FIX_W    (SYNC_FIX_W),
        .FIX_PART (SYNC_FIXED)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .vdi       (vdi),
        .bit_stb   (bit_stb),
        .bit_val   (bit_val),
        .prog_part (sync_low),
        .store_stb (store_stb),
        .store_bit (store_bit)
    );

    rxf_host_sync #(
        .STAGES (2)
    ) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_sclk  (host_sclk),
        .host_sel_n (host_sel_n),
        .sel_active (sel_active),
        .pop_stb    (pop_stb)
    );

    rxf_bit_store #(
        .DEPTH (FIFO_DEPTH),
        .PW    (PTR_W),
        .CW    (CNT_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (store_stb),
        .push_bit (store_bit),
        .pop      (pop_stb),
        .ovf_clr  (ovf_clr),
        .head_bit (head_bit),
        .count    (fill),
        .ovf      (ovf_flag)
    );

    // Drive the host data line and the threshold flag.
    always_comb begin
        host_sdo = sel_active ? head_bit : 1'b0;
        irq_flag = (fill > irq_level);
    end

    assert_irq_needs_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag |-> (fill != '0));
    assert_sdo_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == '0) |-> !host_sdo);
endmodule

// File: tb/sim_rx_bit_fifo.sv
module sim_rx_bit_fifo;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bit_stb = 1'b0;
    logic       bit_val = 1'b0;
    logic       vdi = 1'b0;
    logic [7:0] sync_low = 8'hD4;
    logic [4:0] irq_level = 5'd0;
    logic       ovf_clr = 1'b0;
    logic       host_sel_n = 1'b1;
    logic       host_sclk = 1'b0;
    logic       host_sdo;
    logic       irq_flag;
    logic       ovf_flag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // bench model
    bit          mq[$];
    logic [15:0] m_hist = '0;
    bit          m_locked = 1'b0;
    bit          m_ovf = 1'b0;

    always #4 clk = ~clk;

    rx_bit_fifo u0 (
        .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
        .vdi(vdi), .sync_low(sync_low), .irq_level(irq_level),
        .ovf_clr(ovf_clr), .host_sel_n(host_sel_n), .host_sclk(host_sclk),
        .host_sdo(host_sdo), .irq_flag(irq_flag), .ovf_flag(ovf_flag)
    );

    function automatic bit exp_irq(int level);
        return mq.size() > level;
    endfunction

    function automatic bit exp_head();
        return (mq.size() != 0) ? mq[0] : 1'b0;
    endfunction

    task automatic chk(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic set_vdi(bit v);
        vdi = v;
        if (!v) begin
            m_locked = 1'b0;
            m_hist = '0;
        end
        wait_n(1);
    endtask

    task automatic send_bit(bit b);
        bit_val = b;
        bit_stb = 1'b1;
        if (vdi) begin
            if (m_locked) begin
                if (mq.size() < 16) mq.push_back(b);
                else m_ovf = 1'b1;
            end else begin
                m_hist = {m_hist[14:0], b};
                if (m_hist == {8'h2D, sync_low}) m_locked = 1'b1;
            end
        end
        wait_n(1);
        bit_stb = 1'b0;
        wait_n(1);
    endtask

    task automatic send_word(logic [15:0] w, int nb);
        for (int i = nb - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic send_sync();
        send_word({8'h2D, sync_low}, 16);
    endtask

    task automatic sclk_pulse();
        host_sclk = 1'b1;
        wait_n(4);
        host_sclk = 1'b0;
        wait_n(4);
    endtask

    // drain n bits with select low, checking each head bit
    task automatic drain(int n, string tag);
        host_sel_n = 1'b0;
        wait_n(4);
        for (int i = 0; i < n; i++) begin
            chk(tag, host_sdo, exp_head());
            sclk_pulse();
            if (mq.size() != 0) void'(mq.pop_front());
        end
        chk(tag, host_sdo, exp_head());
        host_sel_n = 1'b1;
        wait_n(4);
        chk("R6", host_sdo, 0);
    endtask

    task automatic level_chk(int lv, string tag);
        irq_level = 5'(lv);
        wait_n(1);
        chk(tag, irq_flag, exp_irq(lv));
    endtask

    task automatic clear_ovf();
        ovf_clr = 1'b1;
        m_ovf = 1'b0;
        wait_n(1);
        ovf_clr = 1'b0;
        wait_n(1);
    endtask

    // watchdog
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                errors++;
                checks++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
                $display("  CHECKS %0d ERRORS %0d", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        wait_n(3);
        rst_n = 1'b1;
        wait_n(2);

        // R1: reset state
        chk("R1", host_sdo, 0);
        chk("R1", ovf_flag, 0);
        level_chk(0, "R1");
        host_sel_n = 1'b0;
        wait_n(4);
        chk("R1", host_sdo, 0);
        host_sel_n = 1'b1;
        wait_n(4);

        // R2: qualifier low, sync word and data are discarded
        send_sync();
        send_word(16'hFFFF, 8);
        level_chk(0, "R2");
        // R2: qualifier high but no sync yet
        set_vdi(1'b1);
        send_word(16'hAAAA, 16);
        send_word(16'h2DD5, 16);
        level_chk(0, "R2");

        // R3: sync then 8 data bits; matching bit itself not stored
        send_sync();
        level_chk(0, "R3");
        send_word(16'h00B6, 8);
        level_chk(7, "R3");
        level_chk(8, "R5");
        level_chk(16, "R5");
        // R6: select high keeps data-out low
        wait_n(4);
        chk("R6", host_sdo, 0);
        // R7: serial clock with select high pops nothing
        sclk_pulse();
        level_chk(7, "R7");
        drain(8, "R10");
        level_chk(0, "R5");

        // R8: pops on empty store
        host_sel_n = 1'b0;
        wait_n(4);
        sclk_pulse();
        sclk_pulse();
        chk("R8", host_sdo, 0);
        level_chk(0, "R8");
        host_sel_n = 1'b1;
        wait_n(4);
        send_bit(1'b1);
        level_chk(0, "R8");
        drain(1, "R8");

        // R4: drop qualifier mid-packet, data kept, relock required
        set_vdi(1'b0);
        set_vdi(1'b1);
        send_sync();
        send_word(16'h000D, 4);
        set_vdi(1'b0);
        level_chk(3, "R4");
        set_vdi(1'b1);
        send_word(16'h0005, 4);
        level_chk(3, "R4");
        level_chk(4, "R4");
        send_sync();
        send_word(16'h0009, 4);
        level_chk(7, "R4");
        drain(8, "R4");

        // R9: overflow
        send_word(16'hC3A5, 16);
        chk("R9", ovf_flag, 0);
        send_word(16'h000F, 4);
        chk("R9", ovf_flag, 1);
        level_chk(15, "R9");
        drain(5, "R9");
        chk("R9", ovf_flag, 1);
        clear_ovf();
        chk("R9", ovf_flag, 0);
        drain(11, "R10");

        // R3: programmable low byte
        set_vdi(1'b0);
        sync_low = 8'h5A;
        set_vdi(1'b1);
        send_word(16'h2DD4, 16);
        send_bit(1'b1);
        level_chk(0, "R3");
        send_word(16'h2D5A, 16);
        send_word(16'h0002, 3);
        level_chk(2, "R3");
        drain(3, "R3");

        // random phase
        for (int it = 0; it < 300; it++) begin
            int op;
            op = int'($urandom_range(0, 6));
            case (op)
                0: set_vdi(($urandom_range(0, 3) != 0));
                1: begin
                    int n;
                    n = int'($urandom_range(1, 6));
                    for (int k = 0; k < n; k++) send_bit(1'($urandom_range(0, 1)));
                end
                2: if (vdi) send_sync();
                3: drain(int'($urandom_range(0, 5)), "R10");
                4: level_chk(int'($urandom_range(0, 16)), "R5");
                5: begin
                    chk("R9", ovf_flag, m_ovf);
                    if ($urandom_range(0, 1) != 0) clear_ovf();
                end
                default: begin
                    sync_low = 8'($urandom_range(0, 255));
                    set_vdi(1'b0);
                end
            endcase
        end
        chk("R9", ovf_flag, m_ovf);
        drain(mq.size(), "R10");
        level_chk(0, "R8");

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule